// File: doc/BRIEF.md
# Burst ROM Read Controller

This block sits on the external-memory side of a chip and turns one internal read request into a read sequence on an 8-bit or 16-bit ROM. The ROM supports page-mode access. A request that needs several bus beats keeps the read strobe asserted for the whole sequence, and only the address steps between beats. The first beat uses a long wait count and can be stretched further by the external wait pin. Later beats use a short wait count of their own and pay no attention to the wait pin. A bus-start strobe marks the first beat only. The number of beats depends on both the access size and the bus width. Writes, and reads that fit in one beat, get a plain single normal access.

Requests use a valid/ready handshake. `req_ready` is high only while the controller is idle, and a request transfers on a rising edge where `req_valid` and `req_ready` are both high. The size, address, bus width, write flag and both wait counts are captured at that edge. While a sequence runs, `req_ready` is low, so the requester is held off for the whole burst. The response has no back-pressure: `rsp_valid` pulses for one cycle together with the assembled `rsp_data`, and the consumer must take it in that cycle.

Top module: `brom_rd_ctrl`

## Requirements
- R1: After reset the controller is idle: `req_ready`=1, `rom_rd`, `rom_we`, `rom_bs` and `rsp_valid` are 0, and `rom_addr` is 0.
- R2: `req_size` encodes 0=byte, 1=halfword, 2=word, 3=16-byte line. A read takes 1, 2, 4 or 16 beats on an 8-bit bus (`bus16`=0), and 1, 1, 2 or 8 beats on a 16-bit bus (`bus16`=1).
- R3: During a read, `rom_rd` rises at the accepting edge and stays high across every beat. It falls on the same edge at which `rsp_valid` rises.
- R4: The first beat lasts 1+`first_wait` cycles (0 to 15 waits). If `ext_wait`=1 at a rising edge where these waits are used up, the beat is extended by one more cycle. `ext_wait` has no effect before that point.
- R5: Each later beat lasts 1+`burst_wait` cycles (0 to 3 waits), and `ext_wait` is ignored during it.
- R6: `rom_bs` is high for exactly the cycles of the first beat of each access and low during every later beat.
- R7: The first beat address is `req_addr` on an 8-bit bus, or `req_addr` with bit 0 cleared on a 16-bit bus. Each later beat adds 1 (8-bit bus) or 2 (16-bit bus). `rom_addr` changes only on falling clock edges.
- R8: Read data is captured at the end of each beat and packed little-endian into `rsp_data`. On an 8-bit bus, beat k fills byte k from `rom_data[7:0]`. On a 16-bit bus, beat k fills bytes 2k and 2k+1 from `rom_data[7:0]` and `rom_data[15:8]`. A byte read on a 16-bit bus puts lane `rom_data[15:8]` (address bit 0 = 1) or `rom_data[7:0]` (bit 0 = 0) into byte 0. All bytes that are not filled read 0.
- R9: A write (`req_write`=1) is a single beat of any size. `rom_we` is high and `rom_bs` is high for that beat, `rom_rd` stays 0, and the response carries all-zero data.
- R10: `req_ready` is high only while idle, and `req_valid` is ignored while busy. `rsp_valid` is a single-cycle pulse that comes after the last beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge; the address output uses the falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted (high only when idle) |
| req_addr | input | AW | Start byte address |
| req_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word, 3 line |
| req_write | input | 1 | 1 = write access (single normal access) |
| bus16 | input | 1 | External data bus width: 0 = 8 bits, 1 = 16 bits |
| first_wait | input | 4 | Wait cycles for the first beat |
| burst_wait | input | 2 | Wait cycles for each later beat |
| ext_wait | input | 1 | External wait request, honoured in the first beat only |
| rom_addr | output | AW | External address, updated on falling edges |
| rom_rd | output | 1 | Read strobe, active high |
| rom_we | output | 1 | Write strobe, active high |
| rom_bs | output | 1 | Bus-start strobe, first beat only |
| rom_data | input | 16 | External read data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_data | output | 8*LINE_BYTES | Assembled response data |

## Verification
The assertions check, on every cycle, the rules that hold between strobes:
- the read and write strobes never overlap;
- bus-start only rises on an accepting edge and never appears without a strobe;
- the read strobe only drops together with the response;
- the response is a single-cycle pulse;
- within a held read strobe the address only steps forward by the bus width.

Other behaviour can only be shown by the bench scenarios against its reference model:
- the exact beat counts for every size and width pair;
- the lengths of the first and later beats;
- the wait pin stalling the first beat but not later ones;
- the byte-lane choice and little-endian packing;
- the half-cycle placement of the address change;
- a request held high during a burst being ignored.

// File: rtl/brom_pkg.sv
`timescale 1ns/1ps
package brom_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_LINE = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FIRST = 2'd1,
    ST_NEXT  = 2'd2
  } ctl_state_e;

endpackage

// File: rtl/brom_beat_plan.sv
`timescale 1ns/1ps
module brom_beat_plan
  import brom_pkg::*;
#(
  parameter int LINE_BYTES = 16,
  localparam int CW = $clog2(LINE_BYTES + 1)
) (
  input  logic [1:0]    size,
  input  logic          bus16,
  input  logic          is_write,
  output logic [CW-1:0] beats,
  output logic          narrow
);

  logic [CW-1:0] total_bytes;
  logic [CW-1:0] half_bytes;

  always_comb begin
    unique case (acc_size_e'(size))
      SZ_BYTE: total_bytes = CW'(1);
      SZ_HALF: total_bytes = CW'(2);
      SZ_WORD: total_bytes = CW'(4);
      default: total_bytes = CW'(LINE_BYTES);
    endcase
  end

  assign half_bytes = total_bytes >> 1;

  always_comb begin
    if (is_write)
      beats = CW'(1);
    else if (bus16)
      beats = (half_bytes == '0) ? CW'(1) : half_bytes;
    else
      beats = total_bytes;
  end

  // a byte read on the wide bus picks one lane instead of a full word
  assign narrow = bus16 && (acc_size_e'(size) == SZ_BYTE);

endmodule

// File: rtl/brom_wait_timer.sv
`timescale 1ns/1ps
module brom_wait_timer #(
  parameter int WW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [WW-1:0] load_val,
  output logic          expired
);

  logic [WW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/brom_data_pack.sv
`timescale 1ns/1ps
module brom_data_pack #(
  parameter int LINE_BYTES = 16,
  localparam int IW = $clog2(LINE_BYTES),
  localparam int DATA_W = 8 * LINE_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              cap,
  input  logic [IW-1:0]     idx,
  input  logic              bus16,
  input  logic              narrow,
  input  logic              lane_hi,
  input  logic [15:0]       rom_data,
  output logic [DATA_W-1:0] data
);

  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
    logic       hit;
    logic [7:0] val;
    logic [7:0] q;

    always_comb begin
      if (!bus16) begin
        hit = (idx == IW'(b));
        val = rom_data[7:0];
      end else if (narrow) begin
        hit = (b == 0);
        val = lane_hi ? rom_data[15:8] : rom_data[7:0];
      end else begin
        hit = (idx == IW'(b / 2));
        val = (b % 2 == 1) ? rom_data[15:8] : rom_data[7:0];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= '0;
      else if (clear)
        q <= '0;
      else if (cap && hit)
        q <= val;
    end

    assign data[8*b +: 8] = q;
  end

endmodule

// File: rtl/brom_addr_drive.sv
`timescale 1ns/1ps
module brom_addr_drive #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] d,
  output logic [AW-1:0] q
);

  // the pin changes half a cycle after the beat address is chosen
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)
      q <= '0;
    else
      q <= d;
  end

endmodule

// File: rtl/brom_rd_ctrl.sv
`timescale 1ns/1ps
module brom_rd_ctrl
  import brom_pkg::*;
#(
  parameter int AW = 16,
  parameter int LINE_BYTES = 16,
  parameter int FIRST_WAIT_W = 4,
  parameter int BURST_WAIT_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [AW-1:0]           req_addr,
  input  logic [1:0]              req_size,
  input  logic                    req_write,
  input  logic                    bus16,
  input  logic [FIRST_WAIT_W-1:0] first_wait,
  input  logic [BURST_WAIT_W-1:0] burst_wait,
  input  logic                    ext_wait,
  output logic [AW-1:0]           rom_addr,
  output logic                    rom_rd,
  output logic                    rom_we,
  output logic                    rom_bs,
  input  logic [15:0]             rom_data,
  output logic                    rsp_valid,
  output logic [8*LINE_BYTES-1:0] rsp_data
);

  localparam int CW = $clog2(LINE_BYTES + 1);
  localparam int IW = $clog2(LINE_BYTES);
  localparam int WW = (FIRST_WAIT_W > BURST_WAIT_W) ? FIRST_WAIT_W : BURST_WAIT_W;

  ctl_state_e            state_q;
  logic                  wr_q, bus16_q, narrow_q, lane_hi_q;
  logic [BURST_WAIT_W-1:0] bw_q;
  logic [CW-1:0]         left_q;
  logic [IW-1:0]         idx_q;
  logic [AW-1:0]         beat_addr_q;
  logic                  rd_q, we_q, bs_q, rsp_q;

  logic [CW-1:0] plan_beats;
  logic          plan_narrow;
  logic          accept, expired, beat_end, last_beat, more_beats;
  logic          tmr_load;
  logic [WW-1:0] tmr_val;

  brom_beat_plan #(.LINE_BYTES(LINE_BYTES)) u_plan (
    .size     (req_size),
    .bus16    (bus16),
    .is_write (req_write),
    .beats    (plan_beats),
    .narrow   (plan_narrow)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  // the wait pin only stretches the first beat, once its waits are spent
  assign beat_end  = ((state_q == ST_FIRST) && expired && !ext_wait) ||
                     ((state_q == ST_NEXT) && expired);
  assign last_beat  = (left_q == CW'(1));
  assign more_beats = beat_end && !last_beat;

  assign tmr_load = accept || more_beats;
  assign tmr_val  = accept ? WW'(first_wait) : WW'(bw_q);

  brom_wait_timer #(.WW(WW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (expired)
  );

  brom_data_pack #(.LINE_BYTES(LINE_BYTES)) u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept),
    .cap      (beat_end && !wr_q),
    .idx      (idx_q),
    .bus16    (bus16_q),
    .narrow   (narrow_q),
    .lane_hi  (lane_hi_q),
    .rom_data (rom_data),
    .data     (rsp_data)
  );

  brom_addr_drive #(.AW(AW)) u_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (beat_addr_q),
    .q     (rom_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      wr_q        <= 1'b0;
      bus16_q     <= 1'b0;
      narrow_q    <= 1'b0;
      lane_hi_q   <= 1'b0;
      bw_q        <= '0;
      left_q      <= '0;
      idx_q       <= '0;
      beat_addr_q <= '0;
      rd_q        <= 1'b0;
      we_q        <= 1'b0;
      bs_q        <= 1'b0;
      rsp_q       <= 1'b0;
    end else begin
      rsp_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q     <= ST_FIRST;
            wr_q        <= req_write;
            bus16_q     <= bus16;
            narrow_q    <= plan_narrow;
            lane_hi_q   <= req_addr[0];
            bw_q        <= burst_wait;
            left_q      <= plan_beats;
            idx_q       <= '0;
            beat_addr_q <= bus16 ? {req_addr[AW-1:1], 1'b0} : req_addr;
            rd_q        <= !req_write;
            we_q        <= req_write;
            bs_q        <= 1'b1;
          end
        end
        default: begin
          if (beat_end) begin
            if (last_beat) begin
              state_q <= ST_IDLE;
              rd_q    <= 1'b0;
              we_q    <= 1'b0;
              bs_q    <= 1'b0;
              rsp_q   <= 1'b1;
            end else begin
              state_q     <= ST_NEXT;
              bs_q        <= 1'b0;
              left_q      <= left_q - 1'b1;
              idx_q       <= idx_q + 1'b1;
              beat_addr_q <= beat_addr_q + (bus16_q ? AW'(2) : AW'(1));
            end
          end
        end
      endcase
    end
  end

  assign rom_rd    = rd_q;
  assign rom_we    = we_q;
  assign rom_bs    = bs_q;
  assign rsp_valid = rsp_q;

endmodule

// File: rtl/brom_rd_ctrl_chk.sv
`timescale 1ns/1ps
module brom_rd_ctrl_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          bus16,
  input logic [AW-1:0] rom_addr,
  input logic          rom_rd,
  input logic          rom_we,
  input logic          rom_bs,
  input logic          rsp_valid
);

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_rd && rom_we));

  // R6
  bs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rom_bs) |-> $past(req_valid && req_ready));

  // R6
  bs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rom_bs |-> (rom_rd || rom_we));

  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rom_rd) |-> rsp_valid);

  // R10
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R10
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_rd || rom_we) |-> !req_ready);

  // R7
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_rd && $past(rom_rd) && (rom_addr != $past(rom_addr))) |->
      (rom_addr == $past(rom_addr) + (bus16 ? AW'(2) : AW'(1))));

endmodule

bind brom_rd_ctrl brom_rd_ctrl_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .bus16     (bus16),
  .rom_addr  (rom_addr),
  .rom_rd    (rom_rd),
  .rom_we    (rom_we),
  .rom_bs    (rom_bs),
  .rsp_valid (rsp_valid)
);

// File: tb/brom_rd_ctrl_test.sv
`timescale 1ns/1ps
module brom_rd_ctrl_test;

  localparam int AW = 16;
  localparam int LB = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = '0;
  logic          req_write = 1'b0;
  logic          bus16 = 1'b0;
  logic [3:0]    first_wait = '0;
  logic [1:0]    burst_wait = '0;
  logic          ext_wait = 1'b0;
  logic [AW-1:0] rom_addr;
  logic          rom_rd, rom_we, rom_bs;
  logic [15:0]   rom_data;
  logic          rsp_valid;
  logic [8*LB-1:0] rsp_data;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] memb(input logic [AW-1:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h3C;
  endfunction

  assign rom_data = bus16 ? {memb(rom_addr | 16'h1), memb(rom_addr & 16'hFFFE)}
                          : {8'hEE, memb(rom_addr)};

  brom_rd_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
    .bus16(bus16), .first_wait(first_wait), .burst_wait(burst_wait),
    .ext_wait(ext_wait), .rom_addr(rom_addr), .rom_rd(rom_rd),
    .rom_we(rom_we), .rom_bs(rom_bs), .rom_data(rom_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  task automatic check(input bit ok, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic int beats_of(input int sz, input bit b16, input bit wr);
    int bytes;
    if (wr) return 1;
    bytes = (sz == 3) ? 16 : (1 << sz);
    if (!b16) return bytes;
    return (bytes < 2) ? 1 : bytes / 2;
  endfunction

  // ---------------- behavioural reference model ----------------
  int          m_state, m_cnt, m_left, m_idx, m_bw;
  bit          m_wr, m_b16, m_narrow, m_hi;
  bit          m_rd, m_we, m_bs, m_rsp;
  logic [AW-1:0] m_addr, m_pin;
  logic [127:0]  m_data;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_left = 0; m_idx = 0; m_bw = 0;
      m_wr = 0; m_b16 = 0; m_narrow = 0; m_hi = 0;
      m_rd = 0; m_we = 0; m_bs = 0; m_rsp = 0; m_addr = '0; m_data = '0;
    end else begin
      m_rsp = 0;
      if (m_state == 0) begin
        if (req_valid) begin
          m_state = 1; m_wr = req_write; m_b16 = bus16; m_bw = burst_wait;
          m_narrow = bus16 && (req_size == 0); m_hi = req_addr[0];
          m_left = beats_of(req_size, bus16, req_write);
          m_cnt = first_wait; m_idx = 0; m_data = '0;
          m_addr = bus16 ? (req_addr & 16'hFFFE) : req_addr;
          m_rd = !req_write; m_we = req_write; m_bs = 1;
        end
      end else if (m_cnt > 0) begin
        m_cnt--;
      end else if (m_state == 1 && ext_wait) begin
        m_cnt = 0;
      end else begin
        if (!m_wr) begin
          if (!m_b16) m_data[m_idx*8 +: 8] = rom_data[7:0];
          else if (m_narrow) m_data[7:0] = m_hi ? rom_data[15:8] : rom_data[7:0];
          else m_data[m_idx*16 +: 16] = rom_data;
        end
        m_left--;
        if (m_left == 0) begin
          m_state = 0; m_rd = 0; m_we = 0; m_bs = 0; m_rsp = 1;
        end else begin
          m_state = 2; m_bs = 0; m_cnt = m_bw; m_idx++;
          m_addr = m_addr + (m_b16 ? 16'd2 : 16'd1);
        end
      end
    end
  end

  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) m_pin = '0;
    else m_pin = m_addr;
  end

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    if (rst_n)
      check(rom_addr == m_pin, "R7 rom_addr before falling edge", rom_addr, m_pin);
    #2;
    if (rst_n) begin
      check(rom_addr == m_pin, "R7 rom_addr", rom_addr, m_pin);
      check(rom_rd == m_rd, "R3 rom_rd", rom_rd, m_rd);
      check(rom_we == m_we, "R9 rom_we", rom_we, m_we);
      check(rom_bs == m_bs, "R6 rom_bs", rom_bs, m_bs);
      check(req_ready == (m_state == 0), "R10 req_ready", req_ready, m_state == 0);
      check(rsp_valid == m_rsp, "R10 rsp_valid", rsp_valid, m_rsp);
      if (m_rsp)
        check(rsp_data == m_data, "R8 rsp_data vs model", rsp_data, m_data);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL R10 watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // one access: ew extra first-beat stall cycles, noisy = wait pin high on later beats,
  // hold = keep a changed request valid while busy
  task automatic run(input logic [AW-1:0] addr, input int sz, input bit b16,
                     input bit wr, input int fw, input int bw, input int ew,
                     input bit noisy, input bit hold);
    int nb, lat, c, exp_lat, base;
    logic [127:0] exp;
    bit seen_rd, seen_we;
    nb = beats_of(sz, b16, wr);
    exp_lat = (fw + 1 + ew) + (nb - 1) * (bw + 1);
    exp = '0;
    if (!wr) begin
      if (!b16) for (int k = 0; k < nb; k++) exp[8*k +: 8] = memb(addr + AW'(k));
      else if (sz == 0) exp[7:0] = memb(addr);
      else begin
        base = addr & 16'hFFFE;
        for (int k = 0; k < 2*nb; k++) exp[8*k +: 8] = memb(AW'(base + k));
      end
    end
    @(posedge clk); #1;
    req_valid = 1; req_addr = addr; req_size = sz[1:0]; req_write = wr;
    bus16 = b16; first_wait = fw[3:0]; burst_wait = bw[1:0];
    c = -1; lat = -1; seen_rd = 0; seen_we = 0;
    while (lat < 0 && c < 200) begin
      @(posedge clk); #1;
      c++;
      ext_wait = (c + 1 <= fw + ew) ? 1'b1 : ((c + 1 > fw + ew + 1) ? noisy : 1'b0);
      if (hold) begin
        req_addr = addr ^ 16'h0100; req_size = 2'd3; req_write = 1'b0;
      end else req_valid = 0;
      #2;
      seen_rd |= rom_rd; seen_we |= rom_we;
      if (rsp_valid) begin
        lat = c;
        check(rsp_data == exp, "R8 rsp_data packing", rsp_data, exp);
      end
    end
    req_valid = 0; ext_wait = 0;
    check(lat == exp_lat, wr ? "R9 write length" : "R2/R4/R5 access length",
          lat, exp_lat);
    if (wr) check(!seen_rd && seen_we, "R9 write strobes", {seen_rd, seen_we}, 2'b01);
    @(posedge clk); #3;
    check(!rsp_valid && req_ready, "R10 pulse ends and idle",
          {rsp_valid, req_ready}, 2'b01);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #3;
    check(req_ready && !rom_rd && !rom_we && !rom_bs && !rsp_valid && rom_addr == 0,
          "R1 reset state", {req_ready, rom_rd, rom_we, rom_bs, rsp_valid}, 5'b10000);
    @(posedge clk); #1; rst_n = 1;
    // R1 idle after release
    @(posedge clk); #3;
    check(req_ready && !rom_rd, "R1 idle after reset", {req_ready, rom_rd}, 2'b10);
    // R2 8-bit bus sizes
    run(16'h0040, 0, 0, 0, 0, 0, 0, 0, 0);
    run(16'h0051, 1, 0, 0, 2, 1, 0, 0, 0);
    run(16'h0063, 2, 0, 0, 1, 3, 2, 1, 0);   // R4 stall, R5 noisy wait ignored
    run(16'h0170, 3, 0, 0, 3, 0, 0, 1, 0);
    // R2/R8 16-bit bus sizes and lanes
    run(16'h0201, 0, 1, 0, 0, 0, 0, 0, 0);
    run(16'h0202, 0, 1, 0, 15, 0, 0, 0, 0);
    run(16'h0305, 1, 1, 0, 0, 0, 0, 0, 0);   // R7 bit 0 cleared
    run(16'h0310, 2, 1, 0, 1, 2, 1, 1, 0);
    run(16'h0420, 3, 1, 0, 0, 0, 0, 0, 1);   // R10 held request ignored
    run(16'h0433, 3, 1, 0, 2, 3, 3, 1, 0);
    // R9 writes
    run(16'h0500, 3, 0, 1, 2, 3, 1, 0, 0);
    run(16'h0502, 2, 1, 1, 0, 0, 0, 0, 0);
    // back to back
    run(16'h06FE, 3, 0, 0, 0, 0, 0, 0, 0);
    run(16'h07F0, 2, 0, 0, 0, 0, 0, 1, 0);
    repeat (4) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule